// File: doc/BRIEF.md
# I2C Register-Access Slave

This block sits on a two-wire I2C bus as a slave and gives the bus master byte-wide access to a register file. The register file lives outside the block. SCL and SDA are brought into the system clock domain, and the block finds START, repeated START and STOP conditions there. It answers to one of two device addresses, chosen by a single select input, so two copies can share one bus. The first byte written after the device address loads an internal register pointer. Each later written byte produces a one-cycle write strobe to that pointer. A read is opened with a repeated START and the read form of the device address. In a read, the block fetches bytes through a combinational read strobe and shifts them out on SDA, most significant bit first.

After every data byte, written or read, the pointer either moves on or stays where it is. It moves on only when it lies inside one of a set of parameterised address ranges. When it moves past the last register address it returns to 0x00. SDA is driven only as an open-drain enable: the block pulls the line low for its acknowledge bits and for read-data bits that are 0, and releases it at all other times.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is asserted and right after it, sda_oe, reg_wr and reg_rd are 0 and reg_addr is 0x00.
- R2: With addr_sel=0 the block acknowledges the address bytes 0x82 (write) and 0x83 (read). With addr_sel=1 it acknowledges 0x88 and 0x89. The acknowledge is sda_oe=1 during the ninth SCL clock of the byte.
- R3: When an address byte does not match the selected address, the block does not acknowledge it. It then drives nothing and strobes nothing until the next START.
- R4: In a write, the byte after the device address loads the pointer. Each following byte is acknowledged and raises reg_wr for one cycle, with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R5: After a repeated START and a matching read address, the block raises reg_rd, with reg_addr equal to the pointer, at the end of the acknowledge bit. It then sends reg_rdata MSB first and pulls SDA low for each 0 bit.
- R6: During a read, a master ACK (SDA low on the ninth clock) starts the fetch and transmission of the next byte. A master NoAck returns the block to idle, and it stays silent until the next START.
- R7: After each written or read byte, the pointer advances by one when it lies in 0x00–0x3F or 0x50–0x5F. Otherwise it stays unchanged.
- R8: An advance from the last register address, 0x5F, sets the pointer to 0x00.
- R9: A STOP ends the transaction and releases SDA. Bits clocked after a STOP and before any START cause no acknowledge and no strobe.
- R10: sda_oe changes only while SCL is low, provided the bus traffic is well formed.
- R11: reg_wr and reg_rd are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_sel | input | 1 | Selects the device address: 0 gives 0x82, 1 gives 0x88 |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe; reg_rdata is sampled in that cycle |
| reg_addr | output | 8 | Current register pointer |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data from the register file, valid combinationally for reg_addr |

## Verification
The checks assume well-formed traffic. SCL stays low and high for several system clocks, and SDA changes only while SCL is low, except at START and STOP. The master never issues START or STOP while the slave is pulling SDA low. Under these conditions an enable change can only follow a synchronised SCL fall. The stimulus keeps to them by working in quarter-bit steps of eight clocks: SDA changes a quarter period after SCL falls, and the bus is sampled in the middle of SCL high. SDA is modelled as a wired-AND of the master's drive and the slave's enable.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [7:0] DEV_ADDR0 = 8'h82,
  parameter logic [7:0] DEV_ADDR1 = 8'h88,
  parameter logic [7:0] REG_LAST  = 8'h5F,
  parameter int         NUM_INC   = 2,
  parameter logic [NUM_INC*8-1:0] INC_LO = {8'h50, 8'h00},
  parameter logic [NUM_INC*8-1:0] INC_HI = {8'h5F, 8'h3F},
  parameter int         SYNC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_sel,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int CW = 4;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_DEV, K_PTR, K_DAT} kind_t;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  wire  scl_s = scl_sh[SYNC-1];
  wire  sda_s = sda_sh[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1; sda_sh <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  st_t        st;
  kind_t      kind;
  logic       rw, bump;
  logic [CW-1:0] cnt;
  logic [6:0] sr;
  logic [7:0] tx, ptr, ptr_nxt;
  logic       in_inc;

  wire [7:0] rx_byte   = {sr, sda_s};
  wire       dev_match = rx_byte[7:1] == (addr_sel ? DEV_ADDR1[7:1] : DEV_ADDR0[7:1]);

  always_comb begin
    in_inc = 1'b0;
    for (int i = 0; i < NUM_INC; i++) begin
      logic [7:0] off, span;
      off  = ptr - INC_LO[i*8 +: 8];
      span = INC_HI[i*8 +: 8] - INC_LO[i*8 +: 8];
      if (off <= span) in_inc = 1'b1;
    end
  end

  assign ptr_nxt  = !in_inc ? ptr : (ptr == REG_LAST ? 8'h00 : ptr + 8'h01);
  assign reg_addr = ptr;
  assign reg_rd   = scl_fall & ~start_det & ~stop_det &
                    ((st == S_ACK && kind == K_DEV && rw) || st == S_MACK);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_DEV; rw <= 1'b0; bump <= 1'b0; cnt <= '0;
      sr <= '0; tx <= '0; ptr <= '0; sda_oe <= 1'b0;
      reg_wr <= 1'b0; reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (start_det) begin
        st <= S_RX; kind <= K_DEV; cnt <= '0; sda_oe <= 1'b0; bump <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0; bump <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sr  <= rx_byte[6:0];
            cnt <= cnt + 1'b1;
            if (cnt == CW'(7)) begin
              case (kind)
                K_DEV: if (dev_match) begin rw <= rx_byte[0]; st <= S_ACKW; end
                       else st <= S_IDLE;
                K_PTR: begin ptr <= rx_byte; st <= S_ACKW; end
                default: begin
                  reg_wr <= 1'b1; reg_wdata <= rx_byte; bump <= 1'b1; st <= S_ACKW;
                end
              endcase
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_ACK;
            bump   <= 1'b0;
            if (bump) ptr <= ptr_nxt;
          end
          S_ACK: if (scl_fall) begin
            cnt <= '0;
            if (kind == K_DEV && rw) begin
              tx <= reg_rdata; sda_oe <= ~reg_rdata[7]; st <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              kind   <= (kind == K_DEV) ? K_PTR : K_DAT;
              st     <= S_RX;
            end
          end
          S_TX: if (scl_rise) cnt <= cnt + 1'b1;
                else if (scl_fall) begin
                  if (cnt == CW'(8)) begin
                    sda_oe <= 1'b0; ptr <= ptr_nxt; st <= S_MACK;
                  end else begin
                    tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
                  end
                end
          S_MACK: if (scl_rise && sda_s) st <= S_IDLE;
                  else if (scl_fall) begin
                    cnt <= '0; tx <= reg_rdata; sda_oe <= ~reg_rdata[7]; st <= S_TX;
                  end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic       stop_seen
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
  // R11
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  // R11
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_oe);
  // R4
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $stable(reg_addr));
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .stop_seen(stop_det)
);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
  localparam int Q = 80;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic [7:0] reg_rdata;
  logic sda_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata;
  wire sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [15:0] wq[$];
  logic [7:0]  rq[$];
  int n_tests = 0, n_fail = 0, oe_bad = 0, pulse_bad = 0;
  logic oe_prev = 1'b0, wr_prev = 1'b0, rd_prev = 1'b0;
  bit done = 0;

  i2c_regslave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin
      if (wq.size() == 0) chk(0, "R3 R9 unexpected write strobe", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = wq.pop_front();
        chk({reg_addr, reg_wdata} == e, "R4 R7 R8 write strobe", {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_rd) begin
      if (rq.size() == 0) chk(0, "R6 R9 unexpected read strobe", reg_addr, 0);
      else begin
        logic [7:0] e;
        e = rq.pop_front();
        chk(reg_addr == e, "R5 R7 R8 read address", reg_addr, e);
      end
    end
    if (sda_oe !== oe_prev && scl) oe_bad++;
    if ((reg_wr && wr_prev) || (reg_rd && rd_prev) || (reg_wr && reg_rd)) pulse_bad++;
    oe_prev = sda_oe; wr_prev = reg_wr; rd_prev = reg_rd;
  end

  task automatic bit_io(input bit b, output bit s);
    #Q sda_m = b;
    #Q scl = 1'b1;
    #Q s = sda_bus;
    #Q scl = 1'b0;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl = 1'b1;
    #Q sda_m = 1'b0;
    #Q scl = 1'b0;
  endtask

  task automatic i2c_restart();
    #Q sda_m = 1'b1;
    #Q scl = 1'b1;
    #Q sda_m = 1'b0;
    #Q scl = 1'b0;
  endtask

  task automatic i2c_stop();
    #Q sda_m = 1'b0;
    #Q scl = 1'b1;
    #Q sda_m = 1'b1;
    #Q;
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); v[i] = s; end
    bit_io(!mack, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit a;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    #(2*Q);
    chk(sda_oe == 0 && reg_wr == 0 && reg_rd == 0 && reg_addr == 8'h00,
        "R1 reset state", {sda_oe, reg_wr, reg_rd, reg_addr}, 0);
    #(2*Q) rst_n = 1'b1;
    #(2*Q);
    chk(sda_oe == 0 && reg_addr == 8'h00, "R1 after reset", {sda_oe, reg_addr}, 0);

    // R2 R4 R7: write two bytes at 0x10
    i2c_start();
    wr_byte(8'h82, a); chk(a, "R2 ack address 0x82", a, 1);
    wr_byte(8'h10, a); chk(a, "R4 ack pointer", a, 1);
    wq.push_back({8'h10, 8'hA5}); wq.push_back({8'h11, 8'h3C});
    wr_byte(8'hA5, a);
    wr_byte(8'h3C, a); chk(a, "R4 ack data", a, 1);
    i2c_stop();

    // R5 R6: read back, then NoAck
    i2c_start();
    wr_byte(8'h82, a); wr_byte(8'h10, a);
    i2c_restart();
    rq.push_back(8'h10); rq.push_back(8'h11);
    wr_byte(8'h83, a); chk(a, "R2 ack address 0x83", a, 1);
    rd_byte(1, v); chk(v == 8'hA5, "R5 read data", v, 8'hA5);
    rd_byte(0, v); chk(v == 8'h3C, "R6 burst continue", v, 8'h3C);
    rd_byte(0, v); chk(v == 8'hFF, "R6 silent after NoAck", v, 8'hFF);
    i2c_stop();

    // R3: wrong address with addr_sel=0
    i2c_start();
    wr_byte(8'h88, a); chk(!a, "R3 no ack on mismatch", a, 0);
    wr_byte(8'h00, a); chk(!a, "R3 silent after mismatch", a, 0);
    wr_byte(8'h55, a);
    i2c_stop();

    // R2 R7: addr_sel=1, fixed pointer at 0x44
    addr_sel = 1'b1;
    i2c_start();
    wr_byte(8'h82, a); chk(!a, "R3 0x82 rejected with addr_sel=1", a, 0);
    i2c_stop();
    i2c_start();
    wr_byte(8'h88, a); chk(a, "R2 ack address 0x88", a, 1);
    wr_byte(8'h44, a);
    wq.push_back({8'h44, 8'h01}); wq.push_back({8'h44, 8'h02}); wq.push_back({8'h44, 8'h03});
    wr_byte(8'h01, a); wr_byte(8'h02, a); wr_byte(8'h03, a);
    i2c_restart();
    rq.push_back(8'h44); rq.push_back(8'h44);
    wr_byte(8'h89, a); chk(a, "R2 ack address 0x89", a, 1);
    rd_byte(1, v); chk(v == 8'h03, "R7 fixed pointer read", v, 8'h03);
    rd_byte(0, v); chk(v == 8'h03, "R7 fixed pointer reread", v, 8'h03);
    i2c_stop();

    // R8: wrap from 0x5F to 0x00
    addr_sel = 1'b0;
    i2c_start();
    wr_byte(8'h82, a); wr_byte(8'h5E, a);
    wq.push_back({8'h5E, 8'h11}); wq.push_back({8'h5F, 8'h22}); wq.push_back({8'h00, 8'h33});
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    i2c_restart();
    wr_byte(8'h82, a); wr_byte(8'h5F, a);
    i2c_restart();
    rq.push_back(8'h5F); rq.push_back(8'h00);
    wr_byte(8'h83, a);
    rd_byte(1, v); chk(v == 8'h22, "R8 read at 0x5F", v, 8'h22);
    rd_byte(0, v); chk(v == 8'h33, "R8 read after wrap", v, 8'h33);
    i2c_stop();

    // R9: bytes after STOP without START are ignored
    i2c_start();
    wr_byte(8'h82, a); wr_byte(8'h30, a);
    wq.push_back({8'h30, 8'h9A});
    wr_byte(8'h9A, a);
    i2c_stop();
    wr_byte(8'hEE, a); chk(!a, "R9 no ack after STOP", a, 0);
    wr_byte(8'h82, a); chk(!a, "R9 address ignored without START", a, 0);
    i2c_stop();
    i2c_start();
    wr_byte(8'h82, a); wr_byte(8'h30, a);
    i2c_restart();
    rq.push_back(8'h30); rq.push_back(8'h31);
    wr_byte(8'h83, a);
    rd_byte(1, v); chk(v == 8'h9A, "R9 last write kept", v, 8'h9A);
    rd_byte(0, v); chk(v == 8'h6B, "R9 next register untouched", v, 8'h6B);
    i2c_stop();

    #(4*Q);
    chk(wq.size() == 0 && rq.size() == 0, "R4 R5 all expected strobes seen",
        wq.size() + rq.size(), 0);
    chk(oe_bad == 0, "R10 sda_oe changed while SCL high", oe_bad, 0);
    chk(pulse_bad == 0, "R11 strobe pulse shape", pulse_bad, 0);
    finish_run();
  end
endmodule